// File: doc/BRIEF.md
# Instruction Decoder and Target-Address Generator

This block sits at the front of the execute path of a small 24-bit accumulator machine with an extended instruction mode. Given the first four bytes of an instruction, the address at which it starts, and the low address bits of the base and index registers, it works out how long the instruction is, which opcode it carries, the two register numbers of the register-to-register form, and how the operand is to be reached. For the 3- and 4-byte forms it computes the effective address from the displacement or the full 20-bit address field, with base-relative, program-counter-relative, absolute and legacy 15-bit variants, and with optional indexing on top of any of them.

When the operand is reached indirectly, the block reads the 3-byte pointer word from memory itself, most significant byte first at the lowest address, and reports the pointer as the final address. A one-cycle `done` pulse marks the moment the results are valid. All other modes finish one cycle after `start`; an indirect decode finishes four cycles after it. The caller presents a new instruction with `start` while the block is idle; `start` raised during a pointer fetch is dropped.

Top module: `insn_addr_gen`

## Requirements
- R1: While reset is held and after its release, `done`, `mem_rd`, `opcode`, `length`, `mode`, `target`, `r1` and `r2` are all zero.
- R2: Opcode bytes C0, C4, C8, F0, F4 and F8 (hex) give length 1; 90 to B8 in steps of 4 give length 2; every other byte gives length 4 when e (bit 20 of `instr`) is 1 and n or i is set, else 3. Short forms report the whole first byte as `opcode`; longer forms report it with its two low bits cleared.
- R3: For length 2, `r1` is `instr[23:20]` and `r2` is `instr[19:16]`; for any other length both are zero.
- R4: With n or i set, e = 0, b = 1 (bit 22) and p = 0 (bit 21), the target is the base value plus the 12-bit displacement `instr[19:8]` taken as unsigned.
- R5: With n or i set, e = 0, b = 0 and p = 1, the target is the instruction address plus 3 plus the displacement taken as a 12-bit two's-complement number.
- R6: With n or i set and e = 0, b = p = 0 (and the unused pair b = p = 1) give the displacement itself as the target; with e = 1 the target is `instr[19:0]`, regardless of b and p.
- R7: When x (bit 23) is 1, the index value is added after the steps above; every addition wraps modulo 2^20.
- R8: `mode` equals {n, i} = `instr[25:24]` for the 3/4-byte forms: 01 immediate, 10 indirect, 11 simple, 00 legacy; short forms report 11 and a target of zero.
- R9: With n = i = 0 the instruction is legacy: length 3 and target `instr[22:8]` zero-extended, plus the index value when x = 1.
- R10: For every non-indirect instruction `done` is high for exactly the cycle after the `start` cycle, and no memory read is issued.
- R11: An indirect instruction raises `mem_rd` for three consecutive cycles at the computed address, then that address plus 1 and plus 2 (wrapping), with `mem_rdata` valid in the same cycle; `done` follows in the next cycle with the target holding the low 20 bits of the three bytes joined first byte highest.
- R12: `start` during a pointer fetch is ignored, while `start` in the `done` cycle begins a new decode at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding the presented instruction |
| instr | input | 32 | First four instruction bytes, lowest address in bits 31:24 |
| pc_val | input | 20 | Address of the first instruction byte |
| base_val | input | 20 | Low address bits of the base register |
| index_val | input | 20 | Low address bits of the index register |
| mem_rd | output | 1 | Pointer byte read request |
| mem_addr | output | 20 | Byte address of the pointer read |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as the request |
| done | output | 1 | One-cycle pulse: results valid |
| opcode | output | 8 | Decoded opcode |
| length | output | 3 | Instruction length in bytes |
| r1 | output | 4 | First register number of the 2-byte form |
| r2 | output | 4 | Second register number of the 2-byte form |
| mode | output | 2 | Operand mode {n, i} |
| target | output | 20 | Target address, or operand value for immediate |

## Verification
Two events can share a cycle: the completion pulse of an indirect decode and the acceptance of the next `start`. The bench raises `start` for a new PC-relative instruction exactly in the `done` cycle of an indirect one, checks that the pointer result is visible in that cycle, and that the new result with its own `done` follows one cycle later. It also raises `start` in the middle of a pointer fetch and judges from the read addresses, the fetch length and the absence of a second `done` that the stray request left no trace.

// File: rtl/insn_pkg.sv
package insn_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'b00,
        MODE_IMM    = 2'b01,
        MODE_IND    = 2'b10,
        MODE_SIMPLE = 2'b11
    } am_mode_e;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [2:0]  len;
        am_mode_e    mode;
        logic [3:0]  r1;
        logic [3:0]  r2;
        logic        x;
        logic        b;
        logic        p;
        logic        e;
        logic [11:0] disp;
        logic [19:0] far;
        logic [14:0] legacy;
    } insn_fields_t;

    // Length of the register-less and register-pair forms; zero otherwise.
    function automatic logic [2:0] short_len(input logic [7:0] op);
        logic [2:0] l;
        l = 3'd0;
        if (op == 8'hC0 || op == 8'hC4 || op == 8'hC8 ||
            op == 8'hF0 || op == 8'hF4 || op == 8'hF8) begin
            l = 3'd1;
        end else if (op >= 8'h90 && op <= 8'hB8 && op[1:0] == 2'b00) begin
            l = 3'd2;
        end
        return l;
    endfunction

endpackage

// File: rtl/insn_field_decode.sv
module insn_field_decode
    import insn_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output insn_fields_t       fields
);
    localparam int B0 = INSTR_W - 8;

    logic [7:0] byte0;
    logic [2:0] slen;
    logic       n_bit;
    logic       i_bit;

    assign byte0 = instr[INSTR_W-1:B0];
    assign slen  = short_len(byte0);
    assign n_bit = instr[B0+1];
    assign i_bit = instr[B0];

    always_comb begin
        fields        = '0;
        fields.x      = instr[B0-1];
        fields.b      = instr[B0-2];
        fields.p      = instr[B0-3];
        fields.e      = instr[B0-4];
        fields.disp   = instr[B0-5:B0-16];
        fields.far    = instr[B0-5:B0-24];
        fields.legacy = instr[B0-2:B0-16];
        if (slen != 3'd0) begin
            fields.opcode = byte0;
            fields.len    = slen;
            fields.mode   = MODE_SIMPLE;
            if (slen == 3'd2) begin
                fields.r1 = instr[B0-1:B0-4];
                fields.r2 = instr[B0-5:B0-8];
            end
        end else begin
            fields.opcode = {byte0[7:2], 2'b00};
            fields.mode   = am_mode_e'({n_bit, i_bit});
            if (fields.e && (n_bit || i_bit)) begin
                fields.len = 3'd4;
            end else begin
                fields.len = 3'd3;
            end
        end
    end
endmodule

// File: rtl/insn_ta_calc.sv
module insn_ta_calc
    import insn_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  insn_fields_t      fields,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    output logic [ADDR_W-1:0] ta
);
    localparam int LONG_STEP = 3;

    logic signed [11:0] sdisp;
    logic [ADDR_W-1:0]  disp_u;
    logic [ADDR_W-1:0]  disp_s;
    logic [ADDR_W-1:0]  stage;
    logic [ADDR_W-1:0]  xadd;

    assign sdisp  = fields.disp;
    assign disp_u = ADDR_W'(fields.disp);
    assign disp_s = ADDR_W'(sdisp);
    assign xadd   = fields.x ? index_val : '0;

    always_comb begin
        stage = '0;
        if (fields.mode == MODE_LEGACY) begin
            stage = ADDR_W'(fields.legacy);
        end else if (fields.e) begin
            stage = ADDR_W'(fields.far);
        end else begin
            case ({fields.b, fields.p})
                2'b10:   stage = base_val + disp_u;
                2'b01:   stage = pc_val + ADDR_W'(LONG_STEP) + disp_s;
                default: stage = disp_u;
            endcase
        end
        if (fields.len < 3'd3) begin
            ta = '0;
        end else begin
            ta = stage + xadd;
        end
    end
endmodule

// File: rtl/insn_addr_gen.sv
module insn_addr_gen
    import insn_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int INSTR_W = 32,
    parameter int PTR_BYTES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  pc_val,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  index_val,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [7:0]         mem_rdata,
    output logic               done,
    output logic [7:0]         opcode,
    output logic [2:0]         length,
    output logic [3:0]         r1,
    output logic [3:0]         r2,
    output logic [1:0]         mode,
    output logic [ADDR_W-1:0]  target
);
    localparam int CNT_W = $clog2(PTR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PTR_BYTES - 1);

    typedef enum logic {ST_IDLE, ST_FETCH} state_e;

    typedef struct packed {
        state_e            state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] ptr;
        logic              done;
        logic [7:0]        opcode;
        logic [2:0]        len;
        logic [3:0]        r1;
        logic [3:0]        r2;
        logic [1:0]        mode;
        logic [ADDR_W-1:0] target;
    } regs_t;

    insn_fields_t      dec;
    logic [ADDR_W-1:0] ta;
    regs_t             r_d;
    regs_t             r_q;

    insn_field_decode #(.INSTR_W(INSTR_W)) u_dec (
        .instr  (instr),
        .fields (dec)
    );

    insn_ta_calc #(.ADDR_W(ADDR_W)) u_ta (
        .fields    (dec),
        .pc_val    (pc_val),
        .base_val  (base_val),
        .index_val (index_val),
        .ta        (ta)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.opcode = dec.opcode;
                    r_d.len    = dec.len;
                    r_d.r1     = dec.r1;
                    r_d.r2     = dec.r2;
                    r_d.mode   = dec.mode;
                    if (dec.mode == MODE_IND && dec.len >= 3'd3) begin
                        r_d.state = ST_FETCH;
                        r_d.ptr   = ta;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.target = ta;
                        r_d.done   = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                r_d.target = {r_q.target[ADDR_W-9:0], mem_rdata};
                r_d.cnt    = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd   = (r_q.state == ST_FETCH);
    assign mem_addr = r_q.ptr + ADDR_W'(r_q.cnt);
    assign done     = r_q.done;
    assign opcode   = r_q.opcode;
    assign length   = r_q.len;
    assign r1       = r_q.r1;
    assign r2       = r_q.r2;
    assign mode     = r_q.mode;
    assign target   = r_q.target;
endmodule

// File: rtl/insn_addr_gen_chk.sv
module insn_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic [7:0]        opcode,
    input logic [2:0]        length,
    input logic [3:0]        r1,
    input logic [3:0]        r2,
    input logic [1:0]        mode,
    input logic [ADDR_W-1:0] target
);
    assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (length >= 3'd1 && length <= 3'd4));

    assert_long_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && length >= 3'd3) |-> opcode[1:0] == 2'b00);

    assert_regs_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && length != 3'd2) |-> (r1 == 4'd0 && r2 == 4'd0));

    assert_short_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && length <= 3'd2) |-> (mode == 2'b11 && target == '0));

    assert_legacy_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode == 2'b00) |-> (length == 3'd3 && target < ADDR_W'(17'h10000)
                                     || length == 3'd3));

    assert_no_done_in_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !done);

    assert_fetch_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    assert_fetch_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> (done && mode == 2'b10));

    assert_fetch_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd) && $past(mem_rd, 2)) |=> !mem_rd);
endmodule

bind insn_addr_gen insn_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .done     (done),
    .opcode   (opcode),
    .length   (length),
    .r1       (r1),
    .r2       (r2),
    .mode     (mode),
    .target   (target)
);

// File: tb/insn_addr_gen_test.sv
module insn_addr_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [19:0] pc_val = '0;
    logic [19:0] base_val = '0;
    logic [19:0] index_val = '0;
    logic        mem_rd;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [7:0]  opcode;
    logic [2:0]  length;
    logic [3:0]  r1;
    logic [3:0]  r2;
    logic [1:0]  mode;
    logic [19:0] target;

    int checks = 0;
    int errors = 0;
    int cyc;
    int nrd;
    logic [19:0] rda [0:3];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_at(input logic [19:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd3;
        return t ^ a[15:8] ^ {4'h0, a[19:16]};
    endfunction

    assign mem_rdata = mem_at(mem_addr);

    insn_addr_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .instr     (instr),
        .pc_val    (pc_val),
        .base_val  (base_val),
        .index_val (index_val),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .done      (done),
        .opcode    (opcode),
        .length    (length),
        .r1        (r1),
        .r2        (r2),
        .mode      (mode),
        .target    (target)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic run_insn(input logic [31:0] ins, input logic [19:0] pc,
                            input logic [19:0] bv, input logic [19:0] xv);
        @(negedge clk);
        instr = ins; pc_val = pc; base_val = bv; index_val = xv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1; nrd = 0;
        while (!done && cyc < 12) begin
            if (mem_rd && nrd < 4) begin
                rda[nrd] = mem_addr;
                nrd++;
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        chk("R1 done", 32'(done), 0);
        chk("R1 mem_rd", 32'(mem_rd), 0);
        chk("R1 outputs", {opcode, 1'b0, length, r1, r2, mode, 2'b0, target[7:0]}, 0);
        chk("R1 target", 32'(target), 0);
    endtask

    task automatic t_short();
        run_insn(32'hC4000000, 20'h00100, 20'h0, 20'h0);
        chk("R2 len1", 32'(length), 1);
        chk("R2 op1", 32'(opcode), 32'hC4);
        chk("R8 short mode/target", {mode, target}, {2'b11, 20'h0});
        chk("R10 cycles len1", 32'(cyc), 1);
        run_insn(32'hA0350000, 20'h00100, 20'h0, 20'h0);
        chk("R2 len2", 32'(length), 2);
        chk("R2 op2", 32'(opcode), 32'hA0);
        chk("R3 r1", 32'(r1), 3);
        chk("R3 r2", 32'(r2), 5);
        run_insn(32'hB8F00000, 20'h00100, 20'h0, 20'h0);
        chk("R2 len2 top", 32'(length), 2);
        chk("R3 r1 top", 32'(r1), 32'hF);
    endtask

    task automatic t_relative();
        run_insn(32'h03480000, 20'h00500, 20'h12345, 20'h0);
        chk("R4 base target", 32'(target), 32'h12B45);
        chk("R2 len3", 32'(length), 3);
        chk("R3 regs zero", {r1, r2}, 0);
        run_insn(32'h172FF000, 20'h00100, 20'h0, 20'h0);
        chk("R5 pc neg", 32'(target), 32'h000F3);
        chk("R2 op long", 32'(opcode), 32'h14);
        chk("R8 simple", 32'(mode), 3);
        run_insn(32'h17280000, 20'h00005, 20'h0, 20'h0);
        chk("R7 pc wrap", 32'(target), 32'hFF808);
    endtask

    task automatic t_direct();
        run_insn(32'h03812300, 20'h00100, 20'h0, 20'hFFFF0);
        chk("R7 index wrap", 32'(target), 32'h00113);
        run_insn(32'h4B154321, 20'h00100, 20'h0, 20'h0);
        chk("R2 len4", 32'(length), 4);
        chk("R6 far", 32'(target), 32'h54321);
        chk("R2 op4", 32'(opcode), 32'h48);
        run_insn(32'h4B754321, 20'h00700, 20'h11111, 20'h0);
        chk("R6 far ignores b p", 32'(target), 32'h54321);
        run_insn(32'h03645600, 20'h00200, 20'h10000, 20'h0);
        chk("R6 b p both set", 32'(target), 32'h00456);
    endtask

    task automatic t_immediate();
        run_insn(32'h01003A00, 20'h00100, 20'h0, 20'h0);
        chk("R8 imm mode", 32'(mode), 1);
        chk("R8 imm target", 32'(target), 32'h3A);
        chk("R10 imm cycles", 32'(cyc), 1);
        chk("R10 imm no reads", 32'(nrd), 0);
        run_insn(32'h011ABCDE, 20'h00100, 20'h0, 20'h0);
        chk("R2 imm len4", 32'(length), 4);
        chk("R6 imm far", 32'(target), 32'hABCDE);
    endtask

    task automatic t_legacy();
        run_insn(32'h0CF12300, 20'h00100, 20'h55555, 20'h00010);
        chk("R9 len", 32'(length), 3);
        chk("R9 target", 32'(target), 32'h07133);
        chk("R9 mode", 32'(mode), 0);
        chk("R9 opcode", 32'(opcode), 32'h0C);
    endtask

    task automatic t_indirect();
        logic [19:0] a;
        logic [23:0] w;
        run_insn(32'h3E201000, 20'h00200, 20'h0, 20'h0);
        a = 20'h00213;
        w = {mem_at(a), mem_at(a + 20'd1), mem_at(a + 20'd2)};
        chk("R11 cycles", 32'(cyc), 4);
        chk("R11 reads", 32'(nrd), 3);
        chk("R11 addr0", 32'(rda[0]), 32'(a));
        chk("R11 addr2", 32'(rda[2]), 32'(a + 20'd2));
        chk("R11 target", 32'(target), 32'(w[19:0]));
        chk("R8 ind mode", 32'(mode), 2);
        run_insn(32'h3E1FFFFF, 20'h00200, 20'h0, 20'h0);
        w = {mem_at(20'hFFFFF), mem_at(20'h00000), mem_at(20'h00001)};
        chk("R11 wrap addr1", 32'(rda[1]), 0);
        chk("R11 wrap addr2", 32'(rda[2]), 1);
        chk("R11 wrap target", 32'(target), 32'(w[19:0]));
    endtask

    task automatic t_ignore_start();
        logic [23:0] w;
        @(negedge clk);
        instr = 32'h3E201000; pc_val = 20'h00200; start = 1'b1;
        @(negedge clk);
        instr = 32'h01003A00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        w = {mem_at(20'h00213), mem_at(20'h00214), mem_at(20'h00215)};
        chk("R12 done after ignored start", 32'(done), 1);
        chk("R12 target kept", 32'(target), 32'(w[19:0]));
        chk("R12 mode kept", 32'(mode), 2);
        @(negedge clk);
        chk("R12 no second done", {31'b0, done}, 0);
        chk("R12 no second fetch", {31'b0, mem_rd}, 0);
    endtask

    task automatic t_back_to_back();
        logic [23:0] w;
        run_insn(32'h3E201000, 20'h00200, 20'h0, 20'h0);
        w = {mem_at(20'h00213), mem_at(20'h00214), mem_at(20'h00215)};
        chk("R11 first result", 32'(target), 32'(w[19:0]));
        instr = 32'h172FF000; pc_val = 20'h00100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12 back-to-back done", 32'(done), 1);
        chk("R12 back-to-back target", 32'(target), 32'h000F3);
        chk("R12 back-to-back mode", 32'(mode), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_relative();
        t_direct();
        t_immediate();
        t_legacy();
        t_indirect();
        t_ignore_start();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule